// File: doc/BRIEF.md
# Strobe-handshake fall-through FIFO array

The block is a first-in first-out store that is written and read with strobes. A writer raises `wr_stb` with a word on `wr_data`, and `wr_ready` shows that the array has room for it. Stored words fall through to `rd_data` without any action by the reader. When `rd_valid` is high, `rd_data` holds a valid word that will not change. The reader takes that word by raising `rd_stb`. Each high period of a strobe moves at most one word. An asynchronous active-low reset empties the array.

Internally the array is a grid of identical storage units, `N_SLICES` wide and `N_STAGES` deep. Each unit holds `UNIT_DEPTH` words of `SLICE_W` bits. Along a chain, the output-valid flag of one unit drives the write strobe of the next unit. The next unit's input-ready flag drives the read strobe of the unit before it. No glue logic sits between stages.

Across the width, the write strobe goes to the first unit of every slice and the read strobe goes to the last unit of every slice. The edge flags are the AND of the per-slice flags. With the defaults, the array stores 192 words of 27 bits. Back-pressure on the write side works like this: while `wr_ready` is low, a strobe has no effect. After a word is taken, `wr_ready` stays low until `wr_stb` has been seen low. On the read side, a strobe with `rd_valid` low removes nothing.

Top module: `strobe_fifo_array`

## Requirements
- R1: Words leave in the order they were accepted. The array accepts N_STAGES*UNIT_DEPTH words (192 by default) before `wr_ready` stays low.
- R2: While `rst_n` is low, `rd_data` is all zeros, `wr_ready` is 1 and `rd_valid` is 0, all immediately and without a clock. Stored words are discarded.
- R3: A word is removed at a rising clock edge where `rd_valid` and `rd_stb` are both 1. `rd_valid` is 0 in the next cycle.
- R4: `rd_data` holds still while `rd_valid` is 1. After a removal, `rd_valid` is 0 for at least one cycle while `rd_data` still shows the old word. A new word appears at the same edge at which `rd_valid` rises.
- R5: When the array runs empty, the last word removed stays on `rd_data`. Only a reset or a newly arriving word replaces it.
- R6: If `rd_stb` is held at 1 while the array is empty and a word is written, that word falls through to `rd_data`. `rd_valid` is 1 for exactly one cycle, and the word is removed and stays on `rd_data`. Words written after it wait, with `rd_valid` at 0, until `rd_stb` returns to 0. The next word is then presented.
- R7: A word is accepted at an edge where `wr_stb` and `wr_ready` are both 1. `wr_ready` is then 0 until `wr_stb` has been sampled 0, so one high period of `wr_stb` writes exactly one word.
- R8: A `wr_stb` while `wr_ready` is 0 is ignored. No stored word is overwritten and no extra word is stored.
- R9: A `rd_stb` while `rd_valid` is 0 is ignored. `rd_data` is unchanged and no word is lost.
- R10: One high period of `rd_stb` removes at most one word. While it stays high after a removal, `rd_valid` stays 0.
- R11: Slice c carries bits [c*SLICE_W +: SLICE_W] of `wr_data` and `rd_data`. `wr_ready` is the AND of the first-stage ready flags and `rd_valid` is the AND of the last-stage valid flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Write strobe; one word per high period |
| wr_ready | output | 1 | Room for a word, write strobe armed |
| wr_data | input | SLICE_W*N_SLICES | Word to store |
| rd_stb | input | 1 | Read strobe; removes the presented word |
| rd_valid | output | 1 | `rd_data` holds a valid, stable word |
| rd_data | output | SLICE_W*N_SLICES | Presented (or last removed) word |

## Verification
The hardest state to reach is a held read strobe that meets an empty array just as a word arrives. The stimulus resets the array, raises `rd_stb`, and keeps it high through one write and then two more. It counts the cycles in which `rd_valid` is high and checks that the later words stay hidden until the strobe drops. The other hard case is the full state. To reach it, the bench fills all 192 words through the three-deep chain without reading, then strobes junk data while `wr_ready` is low. It drains afterwards to prove that nothing was overwritten and the order is intact.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Output stage of one unit: nothing shown, word shown, word taken while
  // the read strobe is still high.
  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_SHOW  = 2'd1,
    OUT_SPENT = 2'd2
  } out_state_e;
endpackage

// File: rtl/sfifo_in_ctrl.sv
module sfifo_in_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic full,
  output logic ready,
  output logic accept
);
  // Set once a word is taken; cleared only after the strobe is seen low.
  logic latched;

  assign ready  = !full && !latched;
  assign accept = strobe && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latched <= 1'b0;
    else if (accept)  latched <= 1'b1;
    else if (!strobe) latched <= 1'b0;
  end
endmodule

// File: rtl/sfifo_ring.sv
module sfifo_ring #(
  parameter int W     = 9,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= step(wp);
      if (rd_en) rp <= step(rp);
      unique case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/sfifo_out_stage.sv
module sfifo_out_stage
  import sfifo_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         have_word,
  input  logic [W-1:0] next_word,
  output logic         load,
  output logic         valid,
  output logic [W-1:0] word_q
);
  out_state_e st, st_nx;

  always_comb begin
    load  = 1'b0;
    st_nx = st;
    unique case (st)
      OUT_IDLE: begin
        if (have_word) begin
          load  = 1'b1;
          st_nx = OUT_SHOW;
        end
      end
      OUT_SHOW: begin
        if (take) st_nx = OUT_SPENT;
      end
      OUT_SPENT: begin
        if (!take) begin
          if (have_word) begin
            load  = 1'b1;
            st_nx = OUT_SHOW;
          end else begin
            st_nx = OUT_IDLE;
          end
        end
      end
      default: st_nx = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= OUT_IDLE;
      word_q <= '0;
    end else begin
      st <= st_nx;
      if (load) word_q <= next_word;
    end
  end

  assign valid = (st == OUT_SHOW);
endmodule

// File: rtl/sfifo_unit.sv
module sfifo_unit #(
  parameter int W     = 9,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         si,
  output logic         ir,
  input  logic [W-1:0] din,
  input  logic         so,
  output logic         ov,
  output logic [W-1:0] dout
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             accept, load, full;
  logic [CNT_W-1:0] ring_cnt, held;
  logic [W-1:0]     ring_q;

  // The shown word still counts toward capacity until it is taken.
  assign held = ring_cnt + CNT_W'(ov);
  assign full = (held == CNT_W'(DEPTH));

  sfifo_in_ctrl u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (si),
    .full   (full),
    .ready  (ir),
    .accept (accept)
  );

  sfifo_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (din),
    .rd_en   (load),
    .rd_data (ring_q),
    .count   (ring_cnt)
  );

  sfifo_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (so),
    .have_word (ring_cnt != '0),
    .next_word (ring_q),
    .load      (load),
    .valid     (ov),
    .word_q    (dout)
  );
endmodule

// File: rtl/strobe_fifo_array.sv
module strobe_fifo_array #(
  parameter int SLICE_W    = 9,
  parameter int UNIT_DEPTH = 64,
  parameter int N_STAGES   = 3,
  parameter int N_SLICES   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb,
  output logic                         wr_ready,
  input  logic [SLICE_W*N_SLICES-1:0]  wr_data,
  input  logic                         rd_stb,
  output logic                         rd_valid,
  output logic [SLICE_W*N_SLICES-1:0]  rd_data
);
  logic               st_si   [N_SLICES][N_STAGES];
  logic               st_ir   [N_SLICES][N_STAGES];
  logic               st_so   [N_SLICES][N_STAGES];
  logic               st_ov   [N_SLICES][N_STAGES];
  logic [SLICE_W-1:0] st_din  [N_SLICES][N_STAGES];
  logic [SLICE_W-1:0] st_dout [N_SLICES][N_STAGES];

  for (genvar c = 0; c < N_SLICES; c++) begin : g_slice
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign st_si[c][s]  = wr_stb;
        assign st_din[c][s] = wr_data[c*SLICE_W +: SLICE_W];
      end else begin : g_link_in
        assign st_si[c][s]  = st_ov[c][s-1];
        assign st_din[c][s] = st_dout[c][s-1];
      end

      if (s == N_STAGES - 1) begin : g_tail
        assign st_so[c][s] = rd_stb;
        assign rd_data[c*SLICE_W +: SLICE_W] = st_dout[c][s];
      end else begin : g_link_out
        assign st_so[c][s] = st_ir[c][s+1];
      end

      sfifo_unit #(.W(SLICE_W), .DEPTH(UNIT_DEPTH)) u_unit (
        .clk   (clk),
        .rst_n (rst_n),
        .si    (st_si[c][s]),
        .ir    (st_ir[c][s]),
        .din   (st_din[c][s]),
        .so    (st_so[c][s]),
        .ov    (st_ov[c][s]),
        .dout  (st_dout[c][s])
      );
    end
  end

  // Composite edge flags: every slice must agree.
  always_comb begin
    wr_ready = 1'b1;
    rd_valid = 1'b1;
    for (int c = 0; c < N_SLICES; c++) begin
      wr_ready = wr_ready & st_ir[c][0];
      rd_valid = rd_valid & st_ov[c][N_STAGES-1];
    end
  end
endmodule

// File: rtl/strobe_fifo_array_chk.sv
module strobe_fifo_array_chk #(
  parameter int BUS_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             wr_ready,
  input logic             rd_stb,
  input logic             rd_valid,
  input logic [BUS_W-1:0] rd_data
);
  // Port-level trackers of the strobe high periods.
  logic rd_after_take, wr_after_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_after_take <= 1'b0;
      wr_after_take <= 1'b0;
    end else begin
      if (rd_valid && rd_stb) rd_after_take <= 1'b1;
      else if (!rd_stb)       rd_after_take <= 1'b0;
      if (wr_stb && wr_ready) wr_after_take <= 1'b1;
      else if (!wr_stb)       wr_after_take <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_outputs_r2: assert (rd_data == '0 && wr_ready && !rd_valid)
        else $error("R2 reset outputs wrong");
    end
  end

  p_take_clears_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_stb |=> !rd_valid)
    else $error("R3 valid after take");

  p_valid_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_valid) && rd_valid |-> $stable(rd_data))
    else $error("R4 data moved while valid");

  p_data_moves_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(rd_valid))
    else $error("R4 data moved without valid rising");

  // Also covers the held-strobe fall-through case (R6).
  p_held_rd_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_after_take && rd_stb |-> !rd_valid)
    else $error("R10 second word in one strobe period");

  p_write_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_ready |=> !wr_ready)
    else $error("R7 ready stayed high after write");

  p_one_write_per_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_after_take && wr_stb |-> !wr_ready)
    else $error("R7 ready rose while strobe still high");
endmodule

bind strobe_fifo_array strobe_fifo_array_chk #(.BUS_W(SLICE_W*N_SLICES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .wr_ready (wr_ready),
  .rd_stb   (rd_stb),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/strobe_fifo_array_tb.sv
module strobe_fifo_array_tb;
  localparam int BUS_W    = 27;
  localparam int CAPACITY = 192;
  localparam int WAIT_LIM = 300;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_stb = 1'b0;
  logic             wr_ready;
  logic [BUS_W-1:0] wr_data = '0;
  logic             rd_stb = 1'b0;
  logic             rd_valid;
  logic [BUS_W-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [BUS_W-1:0] model_q[$];

  always #10 clk = ~clk;

  strobe_fifo_array u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] pat(input int i);
    return {9'(i * 5 + 3), 9'(i ^ 'h1A5), 9'(i)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    #1;
    check(rd_data == '0, "R2 data", 32'(rd_data), 0);
    check(wr_ready == 1'b1, "R2 ready", 32'(wr_ready), 1);
    check(rd_valid == 1'b0, "R2 valid", 32'(rd_valid), 0);
    model_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Waits for room, then one-cycle write strobe.
  task automatic push(input logic [BUS_W-1:0] w);
    int n = 0;
    while (!wr_ready && n < WAIT_LIM) begin
      @(negedge clk);
      n++;
    end
    if (n >= WAIT_LIM) begin
      check(1'b0, "R1 room timeout", 0, 1);
    end else begin
      wr_data = w; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      model_q.push_back(w);
      @(negedge clk);
    end
  endtask

  task automatic pop_check(input string req);
    int n = 0;
    logic [BUS_W-1:0] exp;
    while (!rd_valid && n < WAIT_LIM) begin
      @(negedge clk);
      n++;
    end
    check(rd_valid == 1'b1, "R3 word presented", 32'(rd_valid), 1);
    exp = (model_q.size() > 0) ? model_q.pop_front() : '0;
    check(rd_data == exp, req, 32'(rd_data), 32'(exp));
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(rd_valid == 1'b0, "R3 valid drops", 32'(rd_valid), 0);
    check(rd_data == exp, "R4 old word held", 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    push(pat(1)); push(pat(2)); push(pat(3));
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_data == '0, "R2 async clear", 32'(rd_data), 0);
    check(rd_valid == 1'b0, "R2 async valid", 32'(rd_valid), 0);
    check(wr_ready == 1'b1, "R2 async ready", 32'(wr_ready), 1);
    model_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(rd_valid == 1'b0, "R2 contents discarded", 32'(rd_valid), 0);
  endtask

  task automatic t_fill_drain();
    logic [BUS_W-1:0] last;
    do_reset();
    for (int i = 0; i < CAPACITY; i++) push(pat(i));
    repeat (10) @(negedge clk);
    check(wr_ready == 1'b0, "R1 full at capacity", 32'(wr_ready), 0);
    for (int k = 0; k < 4; k++) begin
      wr_data = 27'h7FFFFFF - 27'(k); wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      @(negedge clk);
      check(wr_ready == 1'b0, "R8 ready stays low", 32'(wr_ready), 0);
    end
    for (int i = 0; i < CAPACITY; i++) begin
      last = model_q[0];
      pop_check("R1 order, R8 no overwrite");
    end
    repeat (10) @(negedge clk);
    check(rd_valid == 1'b0, "R8 no extra word", 32'(rd_valid), 0);
    check(rd_data == last, "R5 last word stays", 32'(rd_data), 32'(last));
  endtask

  task automatic t_held_empty();
    int cnt = 0;
    logic [BUS_W-1:0] w1;
    do_reset();
    rd_stb = 1'b1;
    w1 = pat(40);
    push(w1);
    for (int k = 0; k < 40; k++) begin
      if (rd_valid) cnt++;
      @(negedge clk);
    end
    check(cnt == 1, "R6 one-cycle valid", 32'(cnt), 1);
    check(rd_data == w1, "R6 word stays", 32'(rd_data), 32'(w1));
    void'(model_q.pop_front());
    push(pat(41)); push(pat(42));
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (rd_valid) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R6 later words wait", 32'(cnt), 0);
    check(rd_data == w1, "R6 first word still shown", 32'(rd_data), 32'(w1));
    rd_stb = 1'b0;
    pop_check("R6 next word after release");
    pop_check("R6 queued order");
  endtask

  task automatic t_one_per_period();
    int cnt = 0;
    logic [BUS_W-1:0] w1;
    do_reset();
    w1 = pat(60);
    push(w1); push(pat(61));
    repeat (30) @(negedge clk);
    rd_stb = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (rd_valid) cnt++;
      @(negedge clk);
    end
    check(cnt == 1, "R10 one word per high period", 32'(cnt), 1);
    check(rd_data == w1, "R10 taken word held", 32'(rd_data), 32'(w1));
    void'(model_q.pop_front());
    rd_stb = 1'b0;
    pop_check("R10 second word after release");
  endtask

  task automatic t_ignored_read();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
    end
    check(rd_data == '0, "R9 data unchanged", 32'(rd_data), 0);
    push(pat(77));
    pop_check("R9 word not lost");
  endtask

  task automatic t_write_hold();
    logic [BUS_W-1:0] w;
    do_reset();
    w = pat(90);
    wr_data = w; wr_stb = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b0, "R7 ready low after write", 32'(wr_ready), 0);
    repeat (5) @(negedge clk);
    check(wr_ready == 1'b0, "R7 ready low while strobe high", 32'(wr_ready), 0);
    wr_stb = 1'b0;
    repeat (2) @(negedge clk);
    check(wr_ready == 1'b1, "R7 ready back after strobe low", 32'(wr_ready), 1);
    model_q.push_back(w);
    pop_check("R7 single word stored");
    repeat (20) @(negedge clk);
    check(rd_valid == 1'b0, "R7 no second word", 32'(rd_valid), 0);
  endtask

  task automatic t_slices();
    logic [BUS_W-1:0] w;
    do_reset();
    w = {9'h1FF, 9'h000, 9'h0AA};
    push(w);
    pop_check("R11 word intact");
    check(rd_data[26:18] == 9'h1FF, "R11 slice 2 field", 32'(rd_data[26:18]), 32'h1FF);
    check(rd_data[8:0] == 9'h0AA, "R11 slice 0 field", 32'(rd_data[8:0]), 32'h0AA);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", WATCHDOG, WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    t_reset();
    t_slices();
    t_write_hold();
    t_ignored_read();
    t_one_per_period();
    t_held_empty();
    t_fill_drain();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule